// File: doc/BRIEF.md
# Eight-Line Interrupt Controller

This block collects up to eight interrupt request lines, decides which one the processor should serve next, and hands back an 8-bit type number when the processor acknowledges. A processor sets it up over a small 8-bit bus with one address bit. The setup is a short run of two to four configuration bytes. After that, command bytes set the mask, end service on a level, move the priority order, switch the masking behaviour, arm a poll, or choose which register a read returns.

Requests are either latched on a rising line or follow the line level. Priority is fixed, with line 0 highest, until a rotation or an explicit priority command moves the lowest-priority slot. The block keeps one in-service bit per line. In the normal mode a request reaches the processor only when it outranks every level in service. Cascading to further controllers is not built. The cascade configuration byte is still accepted in its place in the setup sequence and then discarded.

Top module: `pic8_ctrl`

Bus accesses count on every clock edge at which the strobes are low. A write needs `cs_n` and `wr_n` low, a read needs `cs_n` and `rd_n` low, and an acknowledge needs `inta_n` low. Each cycle of a strobe is one access. Read data and the type number appear on `dout` one edge after the access and are held there until the next read or acknowledge.

## Requirements
- R1: After reset `int_out` is 0, the request register reads 0, and the mask register (read with a0=1) reads 0.
- R2: A write with a0=0 and din[4]=1 starts setup and clears the in-service bits, the requests, the mask and the rotation. The following a0=1 byte stores din[7:3] as the type base. An a0=1 cascade byte is expected next only if the first byte had din[1]=0. An a0=1 mode byte is expected next only if the first byte had din[0]=1. After that, a0=1 writes load the mask. On acknowledge, `dout` = {base, level}.
- R3: With the first byte's din[3]=0 (edge mode), a request is latched on a 0-to-1 change of its line and cleared when it is taken. A line that stays high does not request again.
- R4: With din[3]=1 (level mode), the request follows the line. A line that falls before acknowledge leaves no request.
- R5: A mask bit of 1 keeps that line from raising `int_out`. The mask reads back with a0=1.
- R6: Line 0 is highest priority by default. A taken level sets its in-service bit. Requests at or below the highest in-service level are held back, and higher ones get through.
- R7: Command byte (a0=0, din[4:3]=00) with din[7:5]=001 clears the highest-priority in-service bit. With din[7:5]=011 it clears the bit numbered din[2:0].
- R8: din[7:5]=101 ends service like 001 and makes that level lowest priority. 111 ends service like 011 and makes din[2:0] lowest. 110 makes din[2:0] lowest without clearing anything.
- R9: Mode byte bit din[1]=1 selects automatic end of service: an acknowledge sets no in-service bit. Code 100 turns on rotation at each such acknowledge, making the taken level lowest. Code 000 turns it off.
- R10: Command byte (a0=0, din[4:3]=01) with din[6:5]=11 enters special mask mode and din[6:5]=10 leaves it. When din[6]=0, din[5] has no effect. In special mask mode, masked in-service levels do not hold back requests.
- R11: In that command, din[1:0]=10 selects the request register and 11 selects the in-service register for a0=0 reads.
- R12: In that command, din[2]=1 arms a poll. The next read returns {pending, 0000, level} and takes the level as an acknowledge would.
- R13: An acknowledge with nothing pending returns {base, 111} and changes no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| a0 | input | 1 | Register address bit |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or type number, registered |
| irq | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt to processor |
| inta_n | input | 1 | Acknowledge strobe, active low |

## Verification
The checks assume that an acknowledge and a bus write never fall in the same cycle. Under that assumption an in-service change seen one edge after an acknowledge can be blamed on the acknowledge alone. The bench drives every access as a single-cycle strobe from a falling edge, and it runs writes, reads and acknowledges strictly one after another from tasks. Request lines change only between accesses, so each edge or level event is seen in a quiet cycle.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int NLVL = 8;
  localparam int LW   = $clog2(NLVL);
  localparam int BW   = 8;
  localparam int TBW  = BW - LW;

  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_MODE} cfg_st_t;

  // rotate so that element sh lands at index 0 (index 0 = highest priority)
  function automatic logic [NLVL-1:0] rot_dn(input logic [NLVL-1:0] v, input logic [LW-1:0] sh);
    logic [2*NLVL-1:0] d;
    d = {v, v};
    return d[sh +: NLVL];
  endfunction

  // position of first set bit from index 0
  function automatic logic [LW-1:0] first_set(input logic [NLVL-1:0] v);
    logic [LW-1:0] p;
    p = '0;
    for (int i = NLVL - 1; i >= 0; i--)
      if (v[i]) p = LW'(i);
    return p;
  endfunction
endpackage

// File: rtl/pic_req.sv
module pic_req
  import pic8_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lvl_mode,
  input  logic            clr_all,
  input  logic [NLVL-1:0] take_oh,
  input  logic [NLVL-1:0] irq,
  output logic [NLVL-1:0] irr
);
  logic [NLVL-1:0] prev;

  for (genvar g = 0; g < NLVL; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev[g] <= 1'b0;
        irr[g]  <= 1'b0;
      end else begin
        prev[g] <= irq[g];
        if (clr_all)       irr[g] <= 1'b0;
        else if (lvl_mode) irr[g] <= irq[g];
        else               irr[g] <= (irr[g] & ~take_oh[g]) | (irq[g] & ~prev[g]);
      end
    end
  end
endmodule

// File: rtl/pic_prio.sv
module pic_prio
  import pic8_pkg::*;
(
  input  logic [NLVL-1:0] irr,
  input  logic [NLVL-1:0] imr,
  input  logic [NLVL-1:0] isr,
  input  logic            smm,
  input  logic [LW-1:0]   low_lvl,
  output logic            win_valid,
  output logic [LW-1:0]   win_lvl,
  output logic            top_valid,
  output logic [LW-1:0]   top_lvl
);
  logic [LW-1:0]   hi;
  logic [NLVL-1:0] req_r, blk_r, isr_r;
  logic [LW-1:0]   rp, bp, tp;

  assign hi    = low_lvl + LW'(1);
  assign req_r = rot_dn(irr & ~imr, hi);
  assign blk_r = rot_dn(smm ? (isr & ~imr) : isr, hi);
  assign isr_r = rot_dn(isr, hi);
  assign rp    = first_set(req_r);
  assign bp    = first_set(blk_r);
  assign tp    = first_set(isr_r);

  assign win_valid = (|req_r) && (!(|blk_r) || (rp < bp));
  assign win_lvl   = rp + hi;
  assign top_valid = |isr_r;
  assign top_lvl   = tp + hi;
endmodule

// File: rtl/pic_cmd.sv
module pic_cmd
  import pic8_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic            rd_stb,
  input  logic            a0,
  input  logic [BW-1:0]   din,
  output logic            init_p,
  output logic [TBW-1:0]  base,
  output logic            lvl_mode,
  output logic            aeoi,
  output logic            rot_aeoi,
  output logic [NLVL-1:0] imr,
  output logic            smm,
  output logic            sel_isr,
  output logic            poll_armed,
  output logic            eoi_p,
  output logic            eoi_spec,
  output logic            eoi_rot,
  output logic            prio_p,
  output logic [LW-1:0]   cmd_lvl
);
  cfg_st_t st;
  logic    need_casc, need_mode;
  logic    run_cmd, ocw2, ocw3;

  assign init_p   = wr_stb && !a0 && din[4];
  assign run_cmd  = wr_stb && !a0 && !din[4] && (st == ST_RUN);
  assign ocw2     = run_cmd && !din[3];
  assign ocw3     = run_cmd && din[3];
  assign eoi_p    = ocw2 && din[5];
  assign eoi_spec = din[6];
  assign eoi_rot  = din[7];
  assign prio_p   = ocw2 && (din[7:5] == 3'b110);
  assign cmd_lvl  = din[LW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_RUN; base <= '0; lvl_mode <= 1'b0; aeoi <= 1'b0; rot_aeoi <= 1'b0;
      imr <= '0; smm <= 1'b0; sel_isr <= 1'b0; poll_armed <= 1'b0;
      need_casc <= 1'b0; need_mode <= 1'b0;
    end else if (init_p) begin
      st <= ST_BASE; lvl_mode <= din[3]; need_casc <= !din[1]; need_mode <= din[0];
      aeoi <= 1'b0; rot_aeoi <= 1'b0; imr <= '0; smm <= 1'b0; sel_isr <= 1'b0;
      poll_armed <= 1'b0;
    end else begin
      if (rd_stb) poll_armed <= 1'b0;
      if (wr_stb && a0) begin
        unique case (st)
          ST_BASE: begin
            base <= din[BW-1:LW];
            st   <= need_casc ? ST_CASC : (need_mode ? ST_MODE : ST_RUN);
          end
          ST_CASC: st <= need_mode ? ST_MODE : ST_RUN;
          ST_MODE: begin
            aeoi <= din[1];
            st   <= ST_RUN;
          end
          default: imr <= din;
        endcase
      end
      if (ocw2 && din[7:5] == 3'b100) rot_aeoi <= 1'b1;
      if (ocw2 && din[7:5] == 3'b000) rot_aeoi <= 1'b0;
      if (ocw3) begin
        if (din[6])  smm <= din[5];
        if (din[1])  sel_isr <= din[0];
        if (din[2])  poll_armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          a0,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  input  logic [7:0]    irq,
  output logic          int_out,
  input  logic          inta_n
);
  logic            wr_stb, rd_stb, ack_stb;
  logic            init_p, lvl_mode, aeoi, rot_aeoi, smm, sel_isr, poll_armed;
  logic            eoi_p, eoi_spec, eoi_rot, prio_p;
  logic [TBW-1:0]  base;
  logic [NLVL-1:0] imr, irr, isr_q, take_oh;
  logic [LW-1:0]   cmd_lvl, low_lvl, win_lvl, top_lvl, eoi_lvl;
  logic            win_valid, top_valid, ack_take, poll_take, take, eoi_hit;

  assign wr_stb    = !cs_n && !wr_n;
  assign rd_stb    = !cs_n && !rd_n;
  assign ack_stb   = !inta_n;
  assign ack_take  = ack_stb && win_valid;
  assign poll_take = rd_stb && poll_armed && win_valid;
  assign take      = ack_take || poll_take;
  assign take_oh   = take ? (NLVL'(1) << win_lvl) : '0;
  assign eoi_lvl   = eoi_spec ? cmd_lvl : top_lvl;
  assign eoi_hit   = eoi_p && (eoi_spec || top_valid);
  assign int_out   = win_valid;

  pic_cmd u_cmd (
    .clk, .rst_n, .wr_stb, .rd_stb, .a0, .din, .init_p, .base, .lvl_mode, .aeoi,
    .rot_aeoi, .imr, .smm, .sel_isr, .poll_armed, .eoi_p, .eoi_spec, .eoi_rot,
    .prio_p, .cmd_lvl
  );

  pic_req u_req (
    .clk, .rst_n, .lvl_mode, .clr_all(init_p), .take_oh, .irq, .irr
  );

  pic_prio u_prio (
    .irr, .imr, .isr(isr_q), .smm, .low_lvl, .win_valid, .win_lvl, .top_valid, .top_lvl
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q   <= '0;
      low_lvl <= LW'(NLVL - 1);
    end else if (init_p) begin
      isr_q   <= '0;
      low_lvl <= LW'(NLVL - 1);
    end else begin
      if (take && !aeoi)                     isr_q[win_lvl] <= 1'b1;
      if (take && aeoi && rot_aeoi)          low_lvl <= win_lvl;
      if (eoi_hit)                           isr_q[eoi_lvl] <= 1'b0;
      if (eoi_hit && eoi_rot)                low_lvl <= eoi_lvl;
      if (prio_p)                            low_lvl <= cmd_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dout <= '0;
    else if (ack_stb)   dout <= {base, ack_take ? win_lvl : LW'(NLVL - 1)};
    else if (rd_stb) begin
      if (poll_armed)   dout <= {win_valid, {(BW-LW-1){1'b0}}, win_valid ? win_lvl : LW'(0)};
      else if (a0)      dout <= imr;
      else              dout <= sel_isr ? isr_q : irr;
    end
  end
endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk
  import pic8_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            int_out,
  input logic            ack_stb,
  input logic            ack_take,
  input logic            poll_take,
  input logic            poll_armed,
  input logic            wr_stb,
  input logic            init_p,
  input logic            aeoi,
  input logic [NLVL-1:0] imr,
  input logic [NLVL-1:0] irr,
  input logic [NLVL-1:0] isr_q,
  input logic [LW-1:0]   win_lvl,
  input logic [TBW-1:0]  base,
  input logic [7:0]      dout
);
  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> !imr[win_lvl]);

  p_int_has_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> irr[win_lvl]);

  p_ack_sets_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !aeoi && !wr_stb) |=> isr_q[$past(win_lvl)]);

  p_aeoi_keeps_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && aeoi && !wr_stb) |=> $stable(isr_q));

  p_vec_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |=> (dout[7:LW] == $past(base)));

  p_poll_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    poll_take |=> !poll_armed);

  p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_p |=> (isr_q == '0 && imr == '0));
endmodule

bind pic8_ctrl pic8_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .int_out(int_out), .ack_stb(ack_stb), .ack_take(ack_take),
  .poll_take(poll_take), .poll_armed(poll_armed), .wr_stb(wr_stb), .init_p(init_p),
  .aeoi(aeoi), .imr(imr), .irr(irr), .isr_q(isr_q), .win_lvl(win_lvl), .base(base),
  .dout(dout)
);

// File: tb/tb_pic8_ctrl.sv
module tb_pic8_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, a0 = 1'b0, inta_n = 1'b1;
  logic [7:0] din = '0, irq = '0, dout;
  logic       int_out;
  int         n_run = 0, n_bad = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  pic8_ctrl dut (
    .clk, .rst_n, .cs_n, .wr_n, .rd_n, .a0, .din, .dout, .irq, .int_out, .inta_n
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; a0 = a; din = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); cs_n = 0; rd_n = 0; a0 = a;
    @(negedge clk); cs_n = 1; rd_n = 1; v = dout;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); inta_n = 0;
    @(negedge clk); inta_n = 1; v = dout;
  endtask

  task automatic drive(input logic [7:0] v);
    @(negedge clk); irq = v;
    @(negedge clk);
  endtask

  task automatic read_isr(output logic [7:0] v);
    wr(0, 8'h0B); rd(0, v);
  endtask

  task automatic read_irr(output logic [7:0] v);
    wr(0, 8'h0A); rd(0, v);
  endtask

  // single, mode byte present; lvl selects level trigger, ae selects auto end
  task automatic setup(input logic [4:0] b, input logic lvl, input logic ae);
    wr(0, {4'b0001, lvl, 3'b011});
    wr(1, {b, 3'b000});
    wr(1, {6'b0, ae, 1'b1});
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 int after reset", {7'b0, int_out}, 8'h00);
    rd(0, v); chk("R1 request reg", v, 8'h00);
    rd(1, v); chk("R1 mask reg", v, 8'h00);
  endtask

  task automatic t_setup_seq;
    logic [7:0] v;
    wr(0, 8'h11); wr(1, 8'h50); wr(1, 8'hFF); wr(1, 8'h01);
    wr(1, 8'h80); rd(1, v); chk("R2 cascade byte skipped into mask", v, 8'h80);
    wr(0, 8'h12); wr(1, 8'h60);
    wr(1, 8'h3C); rd(1, v); chk("R2 no mode byte, mask follows", v, 8'h3C);
    wr(0, 8'h13); rd(1, v); chk("R2 restart clears mask", v, 8'h00);
  endtask

  task automatic t_edge;
    logic [7:0] v;
    setup(5'h12, 0, 0);
    drive(8'h08); chk("R3 rise raises int", {7'b0, int_out}, 8'h01);
    ack(v); chk("R2 type number", v, {5'h12, 3'd3});
    chk("R3 taken, int drops", {7'b0, int_out}, 8'h00);
    wr(0, 8'h20); chk("R3 held line no new request", {7'b0, int_out}, 8'h00);
    read_isr(v); chk("R7 nonspecific clears", v, 8'h00);
    drive(8'h00);
  endtask

  task automatic t_level;
    logic [7:0] v;
    setup(5'h04, 1, 0);
    drive(8'h20); chk("R4 level raises int", {7'b0, int_out}, 8'h01);
    drive(8'h00); chk("R4 level falls, no request", {7'b0, int_out}, 8'h00);
    read_irr(v); chk("R4 request reg follows line", v, 8'h00);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    setup(5'h01, 0, 0);
    wr(1, 8'h04); drive(8'h04);
    chk("R5 masked line quiet", {7'b0, int_out}, 8'h00);
    rd(1, v); chk("R5 mask readback", v, 8'h04);
    read_irr(v); chk("R11 request reg select", v, 8'h04);
    wr(1, 8'h00); chk("R5 unmask raises int", {7'b0, int_out}, 8'h01);
    ack(v); chk("R5 vector", v, {5'h01, 3'd2});
    read_isr(v); chk("R11 in-service select", v, 8'h04);
    wr(0, 8'h20); drive(8'h00);
  endtask

  task automatic t_nested;
    logic [7:0] v;
    setup(5'h02, 0, 0);
    drive(8'h10); ack(v); chk("R6 take level 4", v, {5'h02, 3'd4});
    drive(8'h50); chk("R6 lower level held back", {7'b0, int_out}, 8'h00);
    drive(8'h52); chk("R6 higher level passes", {7'b0, int_out}, 8'h01);
    ack(v); chk("R6 take level 1", v, {5'h02, 3'd1});
    read_isr(v); chk("R6 two in service", v, 8'h12);
    wr(0, 8'h20); read_isr(v); chk("R7 nonspecific clears highest", v, 8'h10);
    chk("R6 level 6 still held", {7'b0, int_out}, 8'h00);
    wr(0, 8'h64); read_isr(v); chk("R7 specific clears level 4", v, 8'h00);
    ack(v); chk("R6 level 6 now taken", v, {5'h02, 3'd6});
    wr(0, 8'h20); drive(8'h00);
  endtask

  task automatic t_rotate;
    logic [7:0] v;
    setup(5'h03, 0, 0);
    drive(8'h24); ack(v); chk("R8 fixed order picks 2", v, {5'h03, 3'd2});
    wr(0, 8'hA0);
    drive(8'h20); drive(8'h22);
    ack(v); chk("R8 rotated, 5 beats 1", v, {5'h03, 3'd5});
    wr(0, 8'h20); ack(v); chk("R8 then 1", v, {5'h03, 3'd1});
    wr(0, 8'h20); wr(0, 8'hC7);
    drive(8'h00); drive(8'h41);
    ack(v); chk("R8 set priority restores 0 first", v, {5'h03, 3'd0});
    wr(0, 8'hE0); read_isr(v); chk("R8 rotate specific clears", v, 8'h00);
    drive(8'h40); drive(8'h41);
    ack(v); chk("R8 0 now lowest, 6 wins", v, {5'h03, 3'd6});
    wr(0, 8'h20); ack(v); wr(0, 8'h20); drive(8'h00);
  endtask

  task automatic t_aeoi;
    logic [7:0] v;
    setup(5'h08, 0, 1);
    drive(8'h08); ack(v); chk("R9 auto end vector", v, {5'h08, 3'd3});
    read_isr(v); chk("R9 no in-service bit", v, 8'h00);
    drive(8'h00); wr(0, 8'h80);
    drive(8'h12); ack(v); chk("R9 first take 1", v, {5'h08, 3'd1});
    drive(8'h10); drive(8'h11);
    ack(v); chk("R9 rotation made 4 beat 0", v, {5'h08, 3'd4});
    ack(v); chk("R9 then 0", v, {5'h08, 3'd0});
    wr(0, 8'h00); drive(8'h00);
  endtask

  task automatic t_smm;
    logic [7:0] v;
    setup(5'h1F, 0, 0);
    drive(8'h08); ack(v);
    drive(8'h28); chk("R10 normal mode blocks 5", {7'b0, int_out}, 8'h00);
    wr(1, 8'h08); chk("R10 mask alone still blocks", {7'b0, int_out}, 8'h00);
    wr(0, 8'h28); chk("R10 enable bit clear, no effect", {7'b0, int_out}, 8'h00);
    wr(0, 8'h68); chk("R10 special mask passes 5", {7'b0, int_out}, 8'h01);
    ack(v); chk("R10 vector 5", v, {5'h1F, 3'd5});
    wr(0, 8'h48); wr(1, 8'h00);
    read_isr(v); chk("R10 both in service", v, 8'h28);
    wr(0, 8'h20); wr(0, 8'h20); drive(8'h00);
  endtask

  task automatic t_poll;
    logic [7:0] v;
    setup(5'h05, 0, 0);
    drive(8'h40); wr(0, 8'h0C); rd(0, v);
    chk("R12 poll byte", v, 8'h86);
    chk("R12 poll took request", {7'b0, int_out}, 8'h00);
    read_isr(v); chk("R12 poll set in-service", v, 8'h40);
    wr(0, 8'h20); wr(0, 8'h0C); rd(0, v);
    chk("R12 poll nothing pending", v, 8'h00);
    drive(8'h00);
  endtask

  task automatic t_spurious;
    logic [7:0] v;
    setup(5'h0A, 0, 0);
    ack(v); chk("R13 spurious vector", v, {5'h0A, 3'd7});
    read_isr(v); chk("R13 in-service unchanged", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup_seq();
    t_edge();
    t_level();
    t_mask();
    t_nested();
    t_rotate();
    t_aeoi();
    t_smm();
    t_poll();
    t_spurious();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule